// File: doc/BRIEF.md
# GPIO Bank Register File with Bit-Masked Write Aliases

This block holds the pin-control registers for one bank of general-purpose pins. The bank is split into ports of eight pins each. Every port has registers for pin function selection, drive direction, drive value, sampled input level, interrupt flags, interrupt enables and a three-byte interrupt mode field, plus a write-one-to-clear flag port. A host reaches them over a plain single-cycle memory-mapped bus.

Every writable register except the flag-clear port has a second address with bit 11 set. A write to that alias changes only the pins whose mask bit is 1, so software can flip one pin with one store and never has to read, modify and write back. The block drives the pad data and pad enable lines. It samples the pad levels through a two-flop synchronizer. It hands configuration, enables and modes on to a separate interrupt detector, which returns per-pin flag-set pulses.

Top module: `gpio_bank`

## Requirements
- R1: While reset is low, and right after it, every register reads 0, `pad_oe`, `pad_do` and `irq` are 0, and all bus reads return 0 above the register width.
- R2: A write to a plain address `{1'b0, 4'b0000, kind[2:0], port[1:0], 2'b00}` stores `wdata[7:0]` into that port's register of that kind. The kinds are 0 config, 1 direction, 2 drive value, 4 flags and 5 enables. Kind 6 stores `wdata[23:0]` into the mode register. Reads at the same address return the value, zero-extended to 32 bits.
- R3: A write to an alias address (bit 11 set) of kinds 0, 1, 2, 4 or 5 sets register bit n to `wdata[n]` only where `wdata[n+8]` is 1. The other bits keep their value. A mask of zero changes nothing. Alias addresses read the same as their plain addresses.
- R4: A write to the mode alias (kind 6) uses `wdata[31:24]` as the pin mask. For each byte k in 0..2, mode bit `k*8+n` takes `wdata[k*8+n]` only where mask bit n is 1.
- R5: `pad_oe` equals the direction registers, with port p at bits `[p*8+7:p*8]`. `pad_do` equals drive value AND direction, so a pin with direction 0 drives 0.
- R6: The input register (kind 3) returns each pin's `pad_in` level as it was two rising edges earlier. Writes to kind 3 are ignored.
- R7: An `irq_set` bit sets its flag bit on the next edge, and the flag holds until it is cleared. A write to kind 7 clears the flags where `wdata` bits are 1. If a set pulse and a clear hit the same bit in the same cycle, the set wins. Kind 7 reads 0.
- R8: `irq` is 1 exactly when some pin has both its flag bit and its enable bit set.
- R9: Accesses with `addr[1:0]` nonzero, `addr[10:7]` nonzero, or to the alias of kind 3 or kind 7 are unmapped. They read 0 and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address within the bank window |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| irq_set | input | PORTS*8 | Per-pin flag-set pulses from the interrupt detector |
| pad_in | input | PORTS*8 | Asynchronous pad levels |
| pad_do | output | PORTS*8 | Pad drive value |
| pad_oe | output | PORTS*8 | Pad drive enable |
| pin_cfg | output | PORTS*8 | Pin function selection bits |
| pin_level | output | PORTS*8 | Synchronized pad levels |
| irq_enable | output | PORTS*8 | Per-pin interrupt enables |
| irq_mode | output | PORTS*24 | Per-port mode fields, port p at `[p*24+23:p*24]` |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block at its default of four ports. That makes both ends of the port field reachable. It also lets a write to one port be checked for leakage into the three others. Alias writes are driven with masks of all-zero, all-one and single bits across all six alias kinds. Flag set pulses are timed to land on the same edge as clears and as masked flag writes. Unmapped offsets are hit at the alias of the input and clear kinds, at misaligned byte addresses and at a neighbouring bank's window.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int PIN_W  = 8;
  localparam int MODE_W = 3 * PIN_W;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  typedef enum logic [2:0] {
    RK_CFG  = 3'd0,
    RK_DIR  = 3'd1,
    RK_DOUT = 3'd2,
    RK_DIN  = 3'd3,
    RK_FLAG = 3'd4,
    RK_ENA  = 3'd5,
    RK_MODE = 3'd6,
    RK_ACK  = 3'd7
  } reg_kind_e;

  // Byte register update: plain stores the low byte, alias uses [15:8] as a select.
  function automatic logic [PIN_W-1:0] merge_byte(input logic [PIN_W-1:0] old_v,
                                                   input logic [DATA_W-1:0] wd,
                                                   input logic alias_wr);
    logic [PIN_W-1:0] sel;
    sel = alias_wr ? wd[2*PIN_W-1:PIN_W] : {PIN_W{1'b1}};
    return (old_v & ~sel) | (wd[PIN_W-1:0] & sel);
  endfunction

  // Mode register update: alias uses the top byte as a per-pin select for all three bytes.
  function automatic logic [MODE_W-1:0] merge_mode(input logic [MODE_W-1:0] old_v,
                                                   input logic [DATA_W-1:0] wd,
                                                   input logic alias_wr);
    logic [PIN_W-1:0]  sel;
    logic [MODE_W-1:0] res;
    sel = alias_wr ? wd[DATA_W-1:DATA_W-PIN_W] : {PIN_W{1'b1}};
    for (int k = 0; k < 3; k++) begin
      res[k*PIN_W +: PIN_W] = (old_v[k*PIN_W +: PIN_W] & ~sel) | (wd[k*PIN_W +: PIN_W] & sel);
    end
    return res;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_decode.sv
module gpio_decode
  import gpio_pkg::*;
#(
  parameter int PORTS = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic              alias_sel,
  output reg_kind_e         kind,
  output logic [1:0]        port
);
  logic aligned, in_window, port_ok, alias_ok;

  assign kind      = reg_kind_e'(addr[6:4]);
  assign port      = addr[3:2];
  assign alias_sel = addr[11];

  always_comb begin
    aligned   = (addr[1:0] == 2'b00);
    in_window = (addr[10:7] == 4'b0000);
    port_ok   = (int'(port) < PORTS);
    alias_ok  = !(alias_sel && ((kind == RK_DIN) || (kind == RK_ACK)));
    hit       = aligned && in_window && port_ok && alias_ok;
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_alias,
  input  reg_kind_e         wr_kind,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PIN_W-1:0]  set_in,
  output logic [PIN_W-1:0]  cfg_q,
  output logic [PIN_W-1:0]  dir_q,
  output logic [PIN_W-1:0]  dout_q,
  output logic [PIN_W-1:0]  flag_q,
  output logic [PIN_W-1:0]  ena_q,
  output logic [MODE_W-1:0] mode_q
);
  logic [PIN_W-1:0]  cfg_d, dir_d, dout_d, flag_d, ena_d;
  logic [MODE_W-1:0] mode_d;
  logic cfg_ce, dir_ce, dout_ce, flag_ce, ena_ce, mode_ce;

  // Next-state logic
  always_comb begin
    cfg_ce  = wr_en && (wr_kind == RK_CFG);
    dir_ce  = wr_en && (wr_kind == RK_DIR);
    dout_ce = wr_en && (wr_kind == RK_DOUT);
    ena_ce  = wr_en && (wr_kind == RK_ENA);
    mode_ce = wr_en && (wr_kind == RK_MODE);

    cfg_d  = merge_byte(cfg_q,  wr_data, wr_alias);
    dir_d  = merge_byte(dir_q,  wr_data, wr_alias);
    dout_d = merge_byte(dout_q, wr_data, wr_alias);
    ena_d  = merge_byte(ena_q,  wr_data, wr_alias);
    mode_d = merge_mode(mode_q, wr_data, wr_alias);

    flag_d = flag_q;
    if (wr_en && (wr_kind == RK_FLAG)) begin
      flag_d = merge_byte(flag_q, wr_data, wr_alias);
    end else if (wr_en && (wr_kind == RK_ACK)) begin
      flag_d = flag_q & ~wr_data[PIN_W-1:0];
    end
    flag_d  = flag_d | set_in;
    flag_ce = (wr_en && ((wr_kind == RK_FLAG) || (wr_kind == RK_ACK))) || (|set_in);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      dir_q  <= '0;
      dout_q <= '0;
      flag_q <= '0;
      ena_q  <= '0;
      mode_q <= '0;
    end else begin
      if (cfg_ce)  cfg_q  <= cfg_d;
      if (dir_ce)  dir_q  <= dir_d;
      if (dout_ce) dout_q <= dout_d;
      if (flag_ce) flag_q <= flag_d;
      if (ena_ce)  ena_q  <= ena_d;
      if (mode_ce) mode_q <= mode_d;
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int PORTS = 4,
  localparam int NPIN = PORTS * PIN_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_wen,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  input  logic [NPIN-1:0]         irq_set,
  input  logic [NPIN-1:0]         pad_in,
  output logic [NPIN-1:0]         pad_do,
  output logic [NPIN-1:0]         pad_oe,
  output logic [NPIN-1:0]         pin_cfg,
  output logic [NPIN-1:0]         pin_level,
  output logic [NPIN-1:0]         irq_enable,
  output logic [PORTS*MODE_W-1:0] irq_mode,
  output logic                    irq
);
  logic      hit, alias_sel;
  reg_kind_e kind;
  logic [1:0] port;

  logic [PIN_W-1:0]  cfg_a  [PORTS];
  logic [PIN_W-1:0]  dir_a  [PORTS];
  logic [PIN_W-1:0]  dout_a [PORTS];
  logic [PIN_W-1:0]  flag_a [PORTS];
  logic [PIN_W-1:0]  ena_a  [PORTS];
  logic [MODE_W-1:0] mode_a [PORTS];
  logic [NPIN-1:0]   sta_all;
  logic [NPIN-1:0]   dout_all;

  gpio_decode #(.PORTS(PORTS)) u_dec (
    .addr      (bus_addr),
    .hit       (hit),
    .alias_sel (alias_sel),
    .kind      (kind),
    .port      (port)
  );

  gpio_sync #(.W(NPIN)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pin_level)
  );

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic wr_here;
    assign wr_here = bus_wen && hit && (int'(port) == p);

    gpio_port u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_here),
      .wr_alias (alias_sel),
      .wr_kind  (kind),
      .wr_data  (bus_wdata),
      .set_in   (irq_set[p*PIN_W +: PIN_W]),
      .cfg_q    (cfg_a[p]),
      .dir_q    (dir_a[p]),
      .dout_q   (dout_a[p]),
      .flag_q   (flag_a[p]),
      .ena_q    (ena_a[p]),
      .mode_q   (mode_a[p])
    );

    assign pin_cfg   [p*PIN_W  +: PIN_W]  = cfg_a[p];
    assign pad_oe    [p*PIN_W  +: PIN_W]  = dir_a[p];
    assign dout_all  [p*PIN_W  +: PIN_W]  = dout_a[p];
    assign sta_all   [p*PIN_W  +: PIN_W]  = flag_a[p];
    assign irq_enable[p*PIN_W  +: PIN_W]  = ena_a[p];
    assign irq_mode  [p*MODE_W +: MODE_W] = mode_a[p];
  end

  assign pad_do = dout_all & pad_oe;
  assign irq    = |(sta_all & irq_enable);

  // Read multiplexer, same cycle as the address
  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      unique case (kind)
        RK_CFG:  bus_rdata[PIN_W-1:0]  = cfg_a[port];
        RK_DIR:  bus_rdata[PIN_W-1:0]  = dir_a[port];
        RK_DOUT: bus_rdata[PIN_W-1:0]  = dout_a[port];
        RK_DIN:  bus_rdata[PIN_W-1:0]  = pin_level[int'(port)*PIN_W +: PIN_W];
        RK_FLAG: bus_rdata[PIN_W-1:0]  = flag_a[port];
        RK_ENA:  bus_rdata[PIN_W-1:0]  = ena_a[port];
        RK_MODE: bus_rdata[MODE_W-1:0] = mode_a[port];
        RK_ACK:  bus_rdata             = '0;
        default: bus_rdata             = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_pkg::*;
#(
  parameter int PORTS = 4,
  localparam int NPIN = PORTS * PIN_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wen,
  input logic [NPIN-1:0]   irq_set,
  input logic [NPIN-1:0]   pad_in,
  input logic [NPIN-1:0]   pad_do,
  input logic [NPIN-1:0]   pad_oe,
  input logic [NPIN-1:0]   pin_cfg,
  input logic [NPIN-1:0]   pin_level,
  input logic [NPIN-1:0]   sta_all,
  input logic              irq
);
  logic [1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (pad_oe == '0 && pad_do == '0 && irq == 1'b0));

  a_r5_drive_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_do & ~pad_oe) == '0);

  a_r6_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2) |-> (pin_level == $past(pad_in, 2)));

  a_r7_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_set != '0) |=> ((sta_all & $past(irq_set)) == $past(irq_set)));

  a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past((irq_set != '0) || bus_wen));

  a_r9_unmapped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wen && bus_addr[10:7] != 4'b0000) |=>
      ($stable(pad_oe) && $stable(pad_do) && $stable(pin_cfg)));
endmodule

bind gpio_bank gpio_bank_chk #(.PORTS(PORTS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wen   (bus_wen),
  .irq_set   (irq_set),
  .pad_in    (pad_in),
  .pad_do    (pad_do),
  .pad_oe    (pad_oe),
  .pin_cfg   (pin_cfg),
  .pin_level (pin_level),
  .sta_all   (sta_all),
  .irq       (irq)
);

// File: tb/sim_gpio_bank.sv
`timescale 1ns/1ps
module sim_gpio_bank;
  localparam int PORTS = 4;
  localparam int NPIN  = PORTS * 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [11:0]       bus_addr;
  logic              bus_wen;
  logic [31:0]       bus_wdata;
  logic [31:0]       bus_rdata;
  logic [NPIN-1:0]   irq_set;
  logic [NPIN-1:0]   pad_in;
  logic [NPIN-1:0]   pad_do, pad_oe, pin_cfg, pin_level, irq_enable;
  logic [PORTS*24-1:0] irq_mode;
  logic              irq;

  always #4 clk = ~clk;

  gpio_bank #(.PORTS(PORTS)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_set(irq_set),
    .pad_in(pad_in), .pad_do(pad_do), .pad_oe(pad_oe), .pin_cfg(pin_cfg),
    .pin_level(pin_level), .irq_enable(irq_enable), .irq_mode(irq_mode), .irq(irq)
  );

  // Reference model state
  logic [7:0]  m_cfg [PORTS];
  logic [7:0]  m_dir [PORTS];
  logic [7:0]  m_out [PORTS];
  logic [7:0]  m_flg [PORTS];
  logic [7:0]  m_ena [PORTS];
  logic [23:0] m_mod [PORTS];
  logic [NPIN-1:0] m_s1, m_s2;

  int    n_vec = 0;
  int    n_bad = 0;
  int    cyc   = 0;
  string cur_req = "R1";

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit mapped(input logic [11:0] a);
    if (a[1:0] != 0 || a[10:7] != 0) return 0;
    if (a[11] && (a[6:4] == 3 || a[6:4] == 7)) return 0;
    return 1;
  endfunction

  function automatic logic [31:0] model_read(input logic [11:0] a);
    int p;
    p = a[3:2];
    if (!mapped(a)) return 0;
    case (a[6:4])
      0: return {24'h0, m_cfg[p]};
      1: return {24'h0, m_dir[p]};
      2: return {24'h0, m_out[p]};
      3: return {24'h0, m_s2[p*8 +: 8]};
      4: return {24'h0, m_flg[p]};
      5: return {24'h0, m_ena[p]};
      6: return {8'h0, m_mod[p]};
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] mb(input logic [7:0] o, input logic [31:0] d, input bit al);
    logic [7:0] r;
    r = o;
    for (int n = 0; n < 8; n++) if (!al || d[8+n]) r[n] = d[n];
    return r;
  endfunction

  task automatic model_write(input logic [11:0] a, input logic [31:0] d);
    int p;
    bit al;
    p  = a[3:2];
    al = a[11];
    if (!mapped(a)) return;
    case (a[6:4])
      0: m_cfg[p] = mb(m_cfg[p], d, al);
      1: m_dir[p] = mb(m_dir[p], d, al);
      2: m_out[p] = mb(m_out[p], d, al);
      4: m_flg[p] = mb(m_flg[p], d, al);
      5: m_ena[p] = mb(m_ena[p], d, al);
      6: for (int k = 0; k < 3; k++)
           for (int n = 0; n < 8; n++)
             if (!al || d[24+n]) m_mod[p][k*8+n] = d[k*8+n];
      7: m_flg[p] = m_flg[p] & ~d[7:0];
      default: ;
    endcase
  endtask

  task automatic tick(input logic we, input logic [11:0] a, input logic [31:0] d,
                      input logic [NPIN-1:0] setv, input logic [NPIN-1:0] pins);
    logic [NPIN-1:0] e_oe, e_do, e_sta, e_ena;
    bus_wen = we; bus_addr = a; bus_wdata = d; irq_set = setv; pad_in = pins;
    #1;
    chk(cur_req, "read data", bus_rdata, model_read(a));
    @(posedge clk);
    if (we) model_write(a, d);
    for (int p = 0; p < PORTS; p++) m_flg[p] = m_flg[p] | setv[p*8 +: 8];
    m_s2 = m_s1;
    m_s1 = pins;
    @(negedge clk);
    for (int p = 0; p < PORTS; p++) begin
      e_oe [p*8 +: 8] = m_dir[p];
      e_do [p*8 +: 8] = m_dir[p] & m_out[p];
      e_sta[p*8 +: 8] = m_flg[p];
      e_ena[p*8 +: 8] = m_ena[p];
    end
    chk("R5", "pad_oe", pad_oe, e_oe);
    chk("R5", "pad_do", pad_do, e_do);
    chk("R8", "irq", {31'h0, irq}, {31'h0, |(e_sta & e_ena)});
  endtask

  logic [NPIN-1:0] pins_now = '0;

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    tick(1'b1, a, d, '0, pins_now);
  endtask
  task automatic rd(input logic [11:0] a);
    tick(1'b0, a, 32'h0, '0, pins_now);
  endtask

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_bad++;
      $display("FAIL R1 watchdog: got %0d cycles expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wen = 0; bus_addr = '0; bus_wdata = '0; irq_set = '0; pad_in = '0;
    for (int p = 0; p < PORTS; p++) begin
      m_cfg[p] = 0; m_dir[p] = 0; m_out[p] = 0; m_flg[p] = 0; m_ena[p] = 0; m_mod[p] = 0;
    end
    m_s1 = '0; m_s2 = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "pad_oe in reset", pad_oe, 32'h0);
    chk("R1", "irq in reset", {31'h0, irq}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: every register reads zero after reset
    cur_req = "R1";
    for (int p = 0; p < PORTS; p++)
      for (int k = 0; k < 8; k++) rd(12'(k*16 + p*4));

    // R2: plain writes, upper data bits ignored, no leakage between ports
    cur_req = "R2";
    for (int p = 0; p < PORTS; p++) begin
      wr(12'(p*4 + 12'h000), 32'hFFFF_FF00 | (8'hA5 ^ 8'(p)));
      wr(12'(p*4 + 12'h050), 32'h1234_5600 | 8'(p*3+1));
      wr(12'(p*4 + 12'h060), 32'hAB00_0000 | (24'h10203 * (p+1)));
    end
    for (int p = 0; p < PORTS; p++)
      for (int k = 0; k < 8; k++) rd(12'(k*16 + p*4));

    // R5: direction and drive value patterns
    cur_req = "R5";
    wr(12'h014, 32'h0000_000F);
    wr(12'h024, 32'h0000_003C);
    wr(12'h028, 32'h0000_00FF);
    wr(12'h018, 32'h0000_0081);
    wr(12'h01C, 32'h0000_00FF);
    wr(12'h02C, 32'h0000_0055);
    rd(12'h024);

    // R3: masked alias writes
    cur_req = "R3";
    wr(12'h824, 32'h0000_0F05);   // low nibble of port1 drive value -> 5
    rd(12'h024);
    wr(12'h824, 32'h0000_00FF);   // mask zero: no change
    rd(12'h824);
    wr(12'h81C, 32'h0000_0100);   // clear pin 0 direction on port 3
    wr(12'h800, 32'h0000_8080);
    wr(12'h85C, 32'h0000_FF5A);
    rd(12'h000); rd(12'h05C); rd(12'h01C);

    // R4: mode alias with per-pin select in the top byte
    cur_req = "R4";
    wr(12'h864, 32'h0F00_FF00);
    rd(12'h064);
    wr(12'h868, 32'h00FF_FFFF);   // mask zero
    rd(12'h068);
    wr(12'h86C, 32'hFFC3_3C99);
    rd(12'h06C);

    // R6: input synchronizer, writes ignored
    cur_req = "R6";
    for (int i = 0; i < 10; i++) begin
      pins_now = 32'h1357_9BDF ^ (32'h0101_0101 << i);
      rd(12'(12'h030 + (i % 4) * 4));
    end
    wr(12'h030, 32'h0000_00FF);
    rd(12'h030); rd(12'h034); rd(12'h038); rd(12'h03C);

    // R7: flag set, clear and priority
    cur_req = "R7";
    tick(1'b0, 12'h044, 0, 32'h0000_0100, pins_now);
    rd(12'h044);
    tick(1'b1, 12'h074, 32'h0000_0001, 32'h0000_0100, pins_now); // set wins
    rd(12'h044);
    wr(12'h074, 32'h0000_0001);
    rd(12'h044);
    tick(1'b1, 12'h844, 32'h0000_0202, 32'h0000_0400, pins_now);
    rd(12'h044); rd(12'h074);

    // R8: enables gate the interrupt
    cur_req = "R8";
    wr(12'h054, 32'h0000_0002);
    rd(12'h054);
    wr(12'h074, 32'h0000_0002);
    tick(1'b0, 12'h048, 0, 32'h0080_0000, pins_now);
    wr(12'h858, 32'h0000_8080);
    wr(12'h078, 32'h0000_0080);
    rd(12'h048);

    // R9: unmapped offsets
    cur_req = "R9";
    wr(12'h0A0, 32'h0000_00FF);
    wr(12'h094, 32'h0000_00FF);
    wr(12'h830, 32'h0000_FFFF);
    wr(12'h870, 32'h0000_FFFF);
    wr(12'h022, 32'h0000_00FF);
    rd(12'h0A0); rd(12'h830); rd(12'h870); rd(12'h022); rd(12'h070); rd(12'h024);

    // R3: mixed random traffic over mapped and alias addresses
    cur_req = "R3";
    for (int i = 0; i < 400; i++) begin
      logic [11:0] a;
      a = {1'($urandom), 4'b0000, 3'($urandom), 2'($urandom), 2'b00};
      pins_now = $urandom;
      tick(1'($urandom), a, $urandom, ($urandom % 4 == 0) ? NPIN'($urandom) : '0, pins_now);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule